// File: doc/BRIEF.md
# DDR byte-lane word deserializer

This block terminates one narrow input link: an 8-bit data lane, a clock forwarded by the sender and a frame strobe. A byte is captured on every edge of the forwarded clock. A falling-edge byte and the rising-edge byte after it form a 16-bit pair, and two pairs form a 32-bit word, least significant byte first. Inside each event frame the block numbers the words. When the forty-word frame length has been reached, the block drops any further words in that frame.

Completed words, each with its index and a last-word marker, are written into an asynchronous FIFO with Gray-coded pointers. The FIFO is drained in the core clock domain at one word per core cycle. If the strobe drops before a full frame has arrived, a sticky error flag is raised in the core domain, and only the core reset clears it. A synchronised copy of the active-low core reset also resets the link-side logic.

Top module: `ddr_word_deser`

## Requirements
- R1: While the frame strobe is high, a byte is captured on every edge of the link clock. The first byte of a frame is the one captured on the first falling edge with the strobe high. Each falling-edge byte is paired with the byte captured on the next rising edge.
- R2: The four bytes of a word arrive in the order bits 7:0, 15:8, 23:16, 31:24. The word on `wordData` has them in exactly those bit positions.
- R3: `wordIndex` runs 0, 1, 2 and so on within each frame. `frameEnd` is high together with `wordValid` for the word with index FRAME_WORDS-1 (39), and at no other time.
- R4: Each new rising of the frame strobe restarts byte assembly and the word index. Half a word left over from an earlier frame is discarded and never appears in any output word.
- R5: Words beyond the FRAME_WORDS-th word in a frame are discarded, and they do not raise the error flag.
- R6: If the strobe falls before FRAME_WORDS complete words have arrived, `shortFrameErr` goes to 1. It stays at 1 until `coreRstN` is asserted.
- R7: Every accepted word comes out on the core side exactly once, in arrival order, with `wordValid` high for one core cycle per word. No words are lost when frames arrive back to back.
- R8: While `coreRstN` is low, `wordValid`, `frameEnd` and `shortFrameErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| linkClk | input | 1 | Forwarded link clock; bytes are taken on both edges |
| linkByte | input | 8 | Link data lane |
| linkValid | input | 1 | Frame strobe, high for the whole frame |
| coreClk | input | 1 | Core clock domain |
| coreRstN | input | 1 | Active-low reset, also synchronised into the link domain |
| wordData | output | 32 | Assembled word |
| wordValid | output | 1 | One-cycle flag per delivered word |
| wordIndex | output | 6 | Position of the word within its frame |
| frameEnd | output | 1 | High with the last word of a frame |
| shortFrameErr | output | 1 | Sticky short-frame error |

## Verification
On every cycle the assertions check these properties:
- Each word push is preceded by a low-half capture.
- The word count never passes the frame length.
- Both Gray pointers move by at most one bit per clock.
- `frameEnd` is only ever seen with a valid word of the last index.
- The error flag never clears outside reset.

Only the bench's scenarios can show the rest. These are byte order and exact data values, and in-order, loss-free delivery across back-to-back frames. They also cover discarding of a stale half word at a frame restart, dropping of overlong frame tails, and the error flag's set and clear behaviour across resets.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
package ddr_deser_pkg;
  // strobes from the link-side control to the datapath
  typedef struct packed {
    logic captureLow;   // store the current byte pair as the low half
    logic pushWord;     // current pair completes a word: write it out
  } deser_strobe_t;
endpackage

// File: rtl/deser_datapath.sv
`timescale 1ns/1ps
module deser_datapath
  import ddr_deser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                linkClk,
  input  logic                linkRstN,
  input  logic [BYTE_W-1:0]   linkByte,
  input  logic                linkValid,
  input  deser_strobe_t       strobe,
  output logic                pairValid,
  output logic [4*BYTE_W-1:0] wordOut
);
  localparam int PAIR_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] fallByte;
  logic              fallValid;
  logic [PAIR_W-1:0] lowHalf;
  logic [PAIR_W-1:0] pairData;

  // falling-edge half of the DDR capture
  always_ff @(negedge linkClk or negedge linkRstN) begin
    if (!linkRstN) begin
      fallByte  <= '0;
      fallValid <= 1'b0;
    end else begin
      fallByte  <= linkByte;
      fallValid <= linkValid;
    end
  end

  // a pair is valid when the strobe was seen high on both edges
  assign pairValid = fallValid & linkValid;
  // earlier byte (falling edge) is the less significant one
  assign pairData  = {linkByte, fallByte};

  always_ff @(posedge linkClk or negedge linkRstN) begin
    if (!linkRstN) lowHalf <= '0;
    else if (strobe.captureLow) lowHalf <= pairData;
  end

  assign wordOut = {pairData, lowHalf};

  // R1
  push_after_low_chk: assert property (@(posedge linkClk) disable iff (!linkRstN)
    strobe.pushWord |-> $past(strobe.captureLow));
endmodule

// File: rtl/deser_ctrl.sv
`timescale 1ns/1ps
module deser_ctrl
  import ddr_deser_pkg::*;
#(
  parameter int FRAME_WORDS = 40,
  parameter int IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic             linkClk,
  input  logic             linkRstN,
  input  logic             pairValid,
  output deser_strobe_t    strobe,
  output logic [IDX_W-1:0] wordIndex,
  output logic             lastWord,
  output logic             shortErr
);
  localparam int CNT_W = $clog2(FRAME_WORDS + 1);

  logic             prevPair;
  logic             halfSel;
  logic [CNT_W-1:0] wordCount;
  logic             newFrame;
  logic             effSel;
  logic             room;
  logic             frameDrop;

  assign newFrame  = pairValid & ~prevPair;
  assign effSel    = newFrame ? 1'b0 : halfSel;
  assign room      = wordCount < CNT_W'(FRAME_WORDS);
  assign frameDrop = prevPair & ~pairValid;

  assign strobe.captureLow = pairValid & ~effSel;
  assign strobe.pushWord   = pairValid & effSel & room;

  assign wordIndex = IDX_W'(wordCount);
  assign lastWord  = (wordCount == CNT_W'(FRAME_WORDS - 1));

  always_ff @(posedge linkClk or negedge linkRstN) begin
    if (!linkRstN) begin
      prevPair  <= 1'b0;
      halfSel   <= 1'b0;
      wordCount <= '0;
      shortErr  <= 1'b0;
    end else begin
      prevPair <= pairValid;
      if (pairValid) halfSel <= ~effSel;
      if (newFrame) wordCount <= '0;
      else if (strobe.pushWord) wordCount <= wordCount + 1'b1;
      if (frameDrop && (wordCount != CNT_W'(FRAME_WORDS))) shortErr <= 1'b1;
    end
  end

  // R5
  count_limit_chk: assert property (@(posedge linkClk) disable iff (!linkRstN)
    wordCount <= CNT_W'(FRAME_WORDS));

  // R6
  link_err_sticky_chk: assert property (@(posedge linkClk) disable iff (!linkRstN)
    shortErr |=> shortErr);
endmodule

// File: rtl/deser_async_fifo.sv
`timescale 1ns/1ps
module deser_async_fifo #(
  parameter int DATA_W = 39,
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W-1:0]  rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic [PTR_W-1:0]  wrBinNext, rdBinNext;
  logic              full, wrDo, rdDo;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // write side
  assign full      = (wrGray == {~rdGrayS2[PTR_W-1:PTR_W-2], rdGrayS2[PTR_W-3:0]});
  assign wrDo      = wrEn & ~full;
  assign wrBinNext = wrBin + PTR_W'(wrDo);

  always_ff @(posedge wrClk) begin
    if (wrDo) mem[wrBin[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= toGray(wrBinNext);
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
    end
  end

  // read side
  assign empty     = (rdGray == wrGrayS2);
  assign rdDo      = rdEn & ~empty;
  assign rdBinNext = rdBin + PTR_W'(rdDo);
  assign rdData    = mem[rdBin[ADDR_W-1:0]];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= toGray(rdBinNext);
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
    end
  end

  // R7
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R7
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

// File: rtl/ddr_word_deser.sv
`timescale 1ns/1ps
module ddr_word_deser
  import ddr_deser_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int FRAME_WORDS = 40,
  parameter int FIFO_ADDR_W = 5,
  parameter int IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic                linkClk,
  input  logic [BYTE_W-1:0]   linkByte,
  input  logic                linkValid,
  input  logic                coreClk,
  input  logic                coreRstN,
  output logic [4*BYTE_W-1:0] wordData,
  output logic                wordValid,
  output logic [IDX_W-1:0]    wordIndex,
  output logic                frameEnd,
  output logic                shortFrameErr
);
  localparam int WORD_W  = 4 * BYTE_W;
  localparam int ENTRY_W = WORD_W + IDX_W + 1;

  logic [1:0]         linkRstSync;
  logic               linkRstN;
  deser_strobe_t      strobe;
  logic               pairValid;
  logic [WORD_W-1:0]  wordOut;
  logic [IDX_W-1:0]   pushIndex;
  logic               pushLast;
  logic               linkErr;
  logic [1:0]         errSync;
  logic [ENTRY_W-1:0] rdEntry;
  logic               fifoEmpty;

  // reset into link domain: asserted at once, released on link clock
  always_ff @(posedge linkClk or negedge coreRstN) begin
    if (!coreRstN) linkRstSync <= 2'b00;
    else linkRstSync <= {linkRstSync[0], 1'b1};
  end
  assign linkRstN = linkRstSync[1];

  deser_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .linkClk(linkClk), .linkRstN(linkRstN), .linkByte(linkByte),
    .linkValid(linkValid), .strobe(strobe), .pairValid(pairValid),
    .wordOut(wordOut));

  deser_ctrl #(.FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .linkClk(linkClk), .linkRstN(linkRstN), .pairValid(pairValid),
    .strobe(strobe), .wordIndex(pushIndex), .lastWord(pushLast),
    .shortErr(linkErr));

  deser_async_fifo #(.DATA_W(ENTRY_W), .ADDR_W(FIFO_ADDR_W)) u_fifo (
    .wrClk(linkClk), .wrRstN(linkRstN), .wrEn(strobe.pushWord),
    .wrData({wordOut, pushIndex, pushLast}),
    .rdClk(coreClk), .rdRstN(coreRstN), .rdEn(1'b1),
    .rdData(rdEntry), .empty(fifoEmpty));

  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIndex <= '0;
      frameEnd  <= 1'b0;
      errSync   <= 2'b00;
    end else begin
      wordValid <= ~fifoEmpty;
      frameEnd  <= ~fifoEmpty & rdEntry[0];
      if (!fifoEmpty) begin
        wordData  <= rdEntry[ENTRY_W-1 -: WORD_W];
        wordIndex <= rdEntry[IDX_W:1];
      end
      errSync <= {errSync[0], linkErr};
    end
  end
  assign shortFrameErr = errSync[1];

  // R3
  end_index_chk: assert property (@(posedge coreClk) disable iff (!coreRstN)
    frameEnd |-> (wordValid && (wordIndex == IDX_W'(FRAME_WORDS - 1))));

  // R3
  index_range_chk: assert property (@(posedge coreClk) disable iff (!coreRstN)
    wordValid |-> (wordIndex < IDX_W'(FRAME_WORDS)));

  // R6
  err_sticky_chk: assert property (@(posedge coreClk) disable iff (!coreRstN)
    shortFrameErr |=> shortFrameErr);
endmodule

// File: tb/ddr_word_deser_bench.sv
`timescale 1ns/1ps
module ddr_word_deser_bench;
  localparam int NW = 40;

  typedef struct packed {
    logic [31:0] d;
    logic [5:0]  i;
    logic        e;
  } exp_t;

  logic        linkClk = 1'b1;
  logic        coreClk = 1'b0;
  logic        coreRstN = 1'b0;
  logic [7:0]  linkByte = 8'h00;
  logic        linkValid = 1'b0;
  logic [31:0] wordData;
  logic        wordValid;
  logic [5:0]  wordIndex;
  logic        frameEnd;
  logic        shortFrameErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t expQ[$];

  ddr_word_deser u_ddr_word_deser (
    .linkClk(linkClk), .linkByte(linkByte), .linkValid(linkValid),
    .coreClk(coreClk), .coreRstN(coreRstN), .wordData(wordData),
    .wordValid(wordValid), .wordIndex(wordIndex), .frameEnd(frameEnd),
    .shortFrameErr(shortFrameErr));

  always #4 linkClk = ~linkClk;     // 125 MHz link
  always #2.5 coreClk = ~coreClk;   // 200 MHz core

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input int f, input int w);
    return {8'(f), 8'(w), ~8'(w), 8'(w * 3 + f + 1)};
  endfunction

  // driver: bytes LSB first, first byte before a falling edge
  task automatic sendFrame(input int f, input int nWords, input int extraHalves);
    logic [31:0] word;
    @(posedge linkClk);
    #2;
    linkValid = 1'b1;
    for (int w = 0; w < nWords; w++) begin
      word = mkWord(f, w);
      if (w < NW) expQ.push_back({word, 6'(w), w == NW - 1});
      for (int b = 0; b < 4; b++) begin
        linkByte = word[8*b +: 8];
        #4;
      end
    end
    for (int h = 0; h < 2 * extraHalves; h++) begin
      linkByte = 8'hEE;
      #4;
    end
    linkValid = 1'b0;
    linkByte = 8'h00;
    repeat (4) @(posedge linkClk);
  endtask

  task automatic waitDrain();
    repeat (40) @(posedge coreClk);
    #1;
  endtask

  // monitor / scoreboard
  always @(negedge coreClk) begin
    if (coreRstN && !done) begin
      if (wordValid) begin
        if (expQ.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R7 actual=unexpected word %0h expected=none", wordData);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          checkEq("R2 word data", 64'(wordData), 64'(e.d));
          checkEq("R3 word index", 64'(wordIndex), 64'(e.i));
          checkEq("R3 frame end", 64'(frameEnd), 64'(e.e));
        end
      end else if (frameEnd) begin
        checkEq("R3 frameEnd without wordValid", 64'(frameEnd), 64'd0);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (5) @(posedge coreClk);
    #1;
    checkEq("R8 reset wordValid", 64'(wordValid), 64'd0);
    checkEq("R8 reset frameEnd", 64'(frameEnd), 64'd0);
    checkEq("R8 reset error", 64'(shortFrameErr), 64'd0);
    @(negedge coreClk);
    coreRstN = 1'b1;
    repeat (10) @(posedge coreClk);

    // R1 R2 R7: back-to-back full frames
    sendFrame(1, NW, 0);
    sendFrame(2, NW, 0);
    waitDrain();
    checkEq("R7 all words delivered", 64'(expQ.size()), 64'd0);
    checkEq("R6 no error on full frames", 64'(shortFrameErr), 64'd0);

    // R5: overlong frame
    sendFrame(3, NW + 1, 0);
    waitDrain();
    checkEq("R5 tail dropped", 64'(expQ.size()), 64'd0);
    checkEq("R5 no error on long frame", 64'(shortFrameErr), 64'd0);

    // R4: short frame ending in half a word, then a full frame
    sendFrame(4, 3, 1);
    sendFrame(5, NW, 0);
    waitDrain();
    checkEq("R4 restart after partial word", 64'(expQ.size()), 64'd0);
    checkEq("R6 error after short frame", 64'(shortFrameErr), 64'd1);

    // R6: sticky across a good frame
    sendFrame(6, NW, 0);
    waitDrain();
    checkEq("R6 error stays set", 64'(shortFrameErr), 64'd1);

    // R8: reset clears the flag
    @(negedge coreClk);
    coreRstN = 1'b0;
    repeat (3) @(posedge coreClk);
    #1;
    checkEq("R8 reset clears error", 64'(shortFrameErr), 64'd0);
    checkEq("R8 reset wordValid", 64'(wordValid), 64'd0);
    @(negedge coreClk);
    coreRstN = 1'b1;
    repeat (10) @(posedge coreClk);

    sendFrame(7, NW, 0);
    waitDrain();
    checkEq("R7 frame after reset", 64'(expQ.size()), 64'd0);
    checkEq("R6 clear after good frame", 64'(shortFrameErr), 64'd0);

    // R6: plain short frame
    sendFrame(8, 10, 0);
    waitDrain();
    checkEq("R6 short frame words", 64'(expQ.size()), 64'd0);
    checkEq("R6 short frame flag", 64'(shortFrameErr), 64'd1);

    finishRun();
  end
endmodule